// File: doc/BRIEF.md
# Synchronous Burst Read Output Controller

This block sequences the read side of a synchronous burst memory. A start strobe loads a word address. From that point the block steps through consecutive addresses and presents one data word per slot on a registered output bus. A slot is one clock long or two clocks long, chosen by configuration. The storage array sits outside the block. It receives the current address and returns a data word together with a ready flag. When ready is low at a slot boundary, the block inserts a wait slot and does not advance the address.

A WAIT output tells the host whether the word on the bus is usable. Its active level is selectable. Its timing is also selectable: WAIT either marks the invalid slot itself, or it marks the slot just before the invalid one, so that a host with a slow turnaround gets advance warning. To make that warning possible, every fetched word passes through a two-slot output pipeline. The early flag is then simply the validity of the word that will appear next. A burst runs until a stop request. The stop takes effect at the end of the slot in which it arrives.

The configuration bits are taken at burst start. While the block is idle it follows the polarity input, so WAIT sits at the correct inactive level before the next burst begins.

Top module: `sbr_burst_reader`

## Requirements
- R1: After reset the block is idle, `mem_addr_o` is 0, `dout_o` is 0 and `wait_o` is 1 (the inactive level for polarity 0).
- R2: When the block is idle, `start_i` loads `start_addr_i` into `mem_addr_o` on the next clock and also captures the three configuration inputs. `start_i` and any configuration change during a burst have no effect until the burst ends.
- R3: At each slot end where `mem_rdy_i` is 1 and no stop applies, `mem_addr_o` increases by one. It wraps modulo 2^ADDR_W.
- R4: A word sampled from `mem_data_i` at the end of slot k is driven on `dout_o` for the whole of slot k+2. The first slot of a burst (slot 0) begins on the clock after the start strobe.
- R5: At a slot end where `mem_rdy_i` is 0, the address is unchanged. The slot two later is invalid, and `dout_o` is 0 during it.
- R6: With `cfg_hold2` = 0 every slot lasts one clock. With `cfg_hold2` = 1 every slot lasts two clocks, and `dout_o` is stable across both.
- R7: With `cfg_wait_pol` = 0, asserted WAIT is a 0 on `wait_o`. With `cfg_wait_pol` = 1, asserted WAIT is a 1. The inactive level is always the opposite value.
- R8: With `cfg_wait_early` = 0, WAIT is asserted exactly during the slots whose `dout_o` word is invalid. This includes slots 0 and 1 of every burst.
- R9: With `cfg_wait_early` = 1, WAIT is asserted during slot k exactly when slot k+1 will be invalid. With 2-clock slots, the warning covers the whole preceding 2-clock slot.
- R10: A `stop_i` pulse in any clock of an active slot ends the burst at the end of that slot. The block is idle on the next clock, with `dout_o` 0 and WAIT inactive. Any word still in the pipeline is discarded.
- R11: While idle, `dout_o` is 0 and `wait_o` is the inverse of `cfg_wait_pol` as sampled on the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait_pol | input | 1 | WAIT active level (0 = low, 1 = high) |
| cfg_hold2 | input | 1 | Slot length (0 = one clock, 1 = two clocks) |
| cfg_wait_early | input | 1 | WAIT timing (0 = during the invalid slot, 1 = one slot ahead) |
| start_i | input | 1 | Burst start strobe, accepted only while idle |
| start_addr_i | input | ADDR_W | First word address of the burst |
| stop_i | input | 1 | Burst end request, applied at the end of the current slot |
| mem_rdy_i | input | 1 | Storage array has the word at `mem_addr_o` ready |
| mem_data_i | input | DATA_W | Word returned by the storage array |
| mem_addr_o | output | ADDR_W | Current word address sent to the storage array |
| dout_o | output | DATA_W | Burst data output, 0 when not valid |
| wait_o | output | 1 | WAIT indication, level set by `cfg_wait_pol` |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 12. With only 64 addresses, a burst started near the top of the range wraps through zero well within a normal burst length. A burst started at address 62 makes that wrap a directed case. The 12-bit data width keeps the array's address-derived words distinct from the zero shown in invalid and idle slots. Random bursts then combine every setting of polarity, slot length and WAIT timing with ready duty cycles from full to sparse, and with stops that land in either clock of a 2-clock slot.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // configuration captured at burst start
  typedef struct packed {
    logic wait_pol;
    logic hold2;
    logic wait_early;
  } sbr_cfg_t;

  // longest slot in clocks
  localparam int unsigned SBR_MAX_HOLD = 2;

  // pipeline depth between array sample and output bus
  localparam int unsigned SBR_PIPE_DEPTH = 2;

endpackage

// File: rtl/sbr_slot_timer.sv
module sbr_slot_timer #(
  parameter int unsigned MAX_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic hold2,
  output logic slot_end
);

  localparam int unsigned CW = (MAX_HOLD > 1) ? $clog2(MAX_HOLD) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last     = hold2 ? CW'(MAX_HOLD - 1) : '0;
  assign slot_end = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= slot_end ? '0 : cnt + 1'b1;
    end
  end

  AST_SHORT_SLOT: assert property (@(posedge clk) disable iff (rst)
    run && !restart && !hold2 |=> !run || slot_end);  // R6

endmodule

// File: rtl/sbr_addr_seq.sv
module sbr_addr_seq #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_addr;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> addr == $past(load_addr));  // R2

endmodule

// File: rtl/sbr_out_pipe.sv
module sbr_out_pipe #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_dat,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_dat,
  output logic              next_vld
);

  logic              vld [DEPTH];
  logic [DATA_W-1:0] dat [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld[i] <= 1'b0;
        dat[i] <= '0;
      end
    end else if (advance) begin
      vld[0] <= in_vld;
      dat[0] <= in_vld ? in_dat : '0;
      for (int i = 1; i < DEPTH; i++) begin
        vld[i] <= vld[i-1];
        dat[i] <= dat[i-1];
      end
    end
  end

  assign out_vld  = vld[DEPTH-1];
  assign out_dat  = dat[DEPTH-1];
  assign next_vld = vld[DEPTH-2];

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> out_dat == '0);  // R5

endmodule

// File: rtl/sbr_wait_gen.sv
module sbr_wait_gen (
  input  logic busy,
  input  logic pol,
  input  logic early,
  input  logic out_vld,
  input  logic next_vld,
  output logic wait_o
);

  logic asserted;

  always_comb begin
    if (!busy) begin
      asserted = 1'b0;
    end else if (early) begin
      asserted = !next_vld;
    end else begin
      asserted = !out_vld;
    end
    wait_o = asserted ? pol : ~pol;
  end

endmodule

// File: rtl/sbr_burst_reader.sv
module sbr_burst_reader
  import sbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wait_pol,
  input  logic              cfg_hold2,
  input  logic              cfg_wait_early,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              stop_i,
  input  logic              mem_rdy_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              wait_o
);

  sbr_cfg_t cfg_live;
  sbr_cfg_t cfg_q;
  logic     busy;
  logic     stop_pend;
  logic     slot_end;
  logic     start_acc;
  logic     stop_now;
  logic     finish;
  logic     advance;
  logic     out_vld;
  logic     next_vld;

  assign cfg_live = '{wait_pol: cfg_wait_pol, hold2: cfg_hold2, wait_early: cfg_wait_early};

  assign start_acc = !busy && start_i;
  assign stop_now  = stop_pend || stop_i;
  assign finish    = busy && slot_end && stop_now;
  assign advance   = busy && slot_end && !stop_now;

  // configuration follows inputs while idle, frozen while a burst runs
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (!busy) begin
      cfg_q <= cfg_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      stop_pend <= 1'b0;
    end else if (start_acc) begin
      busy      <= 1'b1;
      stop_pend <= 1'b0;
    end else if (finish) begin
      busy      <= 1'b0;
      stop_pend <= 1'b0;
    end else if (busy && stop_i) begin
      stop_pend <= 1'b1;
    end
  end

  sbr_slot_timer #(.MAX_HOLD(SBR_MAX_HOLD)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .restart  (start_acc),
    .hold2    (cfg_q.hold2),
    .slot_end (slot_end)
  );

  sbr_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (start_acc),
    .load_addr (start_addr_i),
    .step      (advance && mem_rdy_i),
    .addr      (mem_addr_o)
  );

  sbr_out_pipe #(.DATA_W(DATA_W), .DEPTH(SBR_PIPE_DEPTH)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_acc || finish),
    .advance  (advance),
    .in_vld   (mem_rdy_i),
    .in_dat   (mem_data_i),
    .out_vld  (out_vld),
    .out_dat  (dout_o),
    .next_vld (next_vld)
  );

  sbr_wait_gen u_wait (
    .busy     (busy),
    .pol      (cfg_q.wait_pol),
    .early    (cfg_q.wait_early),
    .out_vld  (out_vld),
    .next_vld (next_vld),
    .wait_o   (wait_o)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy |-> dout_o == '0);  // R11

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    busy && slot_end && mem_rdy_i && !stop_now |=> mem_addr_o == $past(mem_addr_o) + 1'b1);  // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && slot_end && !mem_rdy_i |=> $stable(mem_addr_o));  // R5

  AST_MID_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
    busy && !slot_end |=> $stable(dout_o));  // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && !finish |=> $stable(cfg_q));  // R2

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy && dout_o == '0 && wait_o == !cfg_q.wait_pol);  // R10

endmodule

// File: tb/sim_sbr_burst_reader.sv
module sim_sbr_burst_reader;
  localparam int AW = 6;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cfg_pol = 1'b0, cfg_h2 = 1'b0, cfg_er = 1'b0;
  logic          start = 1'b0, stop = 1'b0, rdy = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [DW-1:0] mem_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dout;
  logic          wait_s;

  sbr_burst_reader #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cfg_wait_pol(cfg_pol), .cfg_hold2(cfg_h2),
    .cfg_wait_early(cfg_er), .start_i(start), .start_addr_i(saddr),
    .stop_i(stop), .mem_rdy_i(rdy), .mem_data_i(mem_data),
    .mem_addr_o(mem_addr), .dout_o(dout), .wait_o(wait_s)
  );

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
    return (DW'(a) * DW'(467)) ^ DW'(12'hA5C);
  endfunction

  assign mem_data = fdat(mem_addr);

  int nchk = 0;
  int nerr = 0;
  logic track = 1'b0;

  // reference state built from the requirements
  logic          m_act = 0, m_ph = 0, m_stp = 0, m_pol = 0, m_h2 = 0, m_er = 0;
  logic          m_s1v = 0, m_ov = 0;
  logic [DW-1:0] m_s1d = '0, m_od = '0;
  logic [AW-1:0] m_addr = '0;

  always @(posedge clk) begin : model
    logic se;
    logic sn;
    if (rst) begin
      m_act = 0; m_ph = 0; m_stp = 0; m_pol = 0; m_h2 = 0; m_er = 0;
      m_s1v = 0; m_ov = 0; m_s1d = '0; m_od = '0; m_addr = '0;
    end else if (!m_act) begin
      m_pol = cfg_pol;
      if (start) begin
        m_act = 1; m_ph = 0; m_stp = 0; m_addr = saddr; m_h2 = cfg_h2; m_er = cfg_er;
        m_s1v = 0; m_ov = 0; m_s1d = '0; m_od = '0;
      end
    end else begin
      se = !m_h2 || m_ph;
      sn = m_stp || stop;
      if (se) begin
        m_ph = 0;
        if (sn) begin
          m_act = 0; m_stp = 0; m_s1v = 0; m_ov = 0; m_s1d = '0; m_od = '0;
        end else begin
          m_ov = m_s1v; m_od = m_s1d;
          m_s1v = rdy; m_s1d = rdy ? fdat(m_addr) : '0;
          if (rdy) m_addr = m_addr + 1'b1;
        end
      end else begin
        m_ph = 1;
        if (stop) m_stp = 1;
      end
    end
  end

  function automatic logic exp_wait();
    logic a;
    a = m_act && (m_er ? !m_s1v : !m_ov);
    return a ? m_pol : ~m_pol;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && track) begin
      check(m_act ? "R3" : "R11", 32'(mem_addr), 32'(m_addr));
      check(!m_act ? "R11" : (m_h2 ? "R6" : "R4"), 32'(dout), 32'(m_od));
      check(!m_act ? "R11" : (m_er ? "R9" : (m_pol ? "R7" : "R8")), 32'(wait_s), 32'(exp_wait()));
    end
  end

  task automatic burst(input logic [AW-1:0] sa, input logic h2, input logic er,
                       input logic pl, input int len, input int pct);
    cfg_h2 = h2; cfg_er = er; cfg_pol = pl;
    @(negedge clk);
    start = 1; saddr = sa;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < len; i++) begin
      rdy = 1'(($urandom % 100) < pct);
      @(negedge clk);
    end
    stop = 1;
    @(negedge clk);
    stop = 0;
    while (m_act) begin
      rdy = 1'($urandom % 2);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog expired got=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", 32'(mem_addr), 0);
    check("R1", 32'(dout), 0);
    check("R1", 32'(wait_s), 1);
    track = 1;

    // R7: idle inactive level follows polarity
    cfg_pol = 1; @(negedge clk); @(negedge clk);
    check("R7", 32'(wait_s), 0);
    cfg_pol = 0; @(negedge clk); @(negedge clk);
    check("R7", 32'(wait_s), 1);

    // R3: wrap through zero
    burst(6'd62, 0, 0, 0, 20, 100);

    // R5: ready low holds address and keeps WAIT asserted
    cfg_h2 = 0; cfg_er = 0; cfg_pol = 1; rdy = 0;
    @(negedge clk);
    start = 1; saddr = 6'd10; @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    check("R5", 32'(mem_addr), 10);
    check("R5", 32'(wait_s), 1);
    check("R5", 32'(dout), 0);
    rdy = 1; repeat (4) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    repeat (2) @(negedge clk);

    // R2 and R10: ignored start and config change, stop in a two-clock slot
    cfg_h2 = 1; cfg_er = 1; cfg_pol = 0; rdy = 1;
    @(negedge clk);
    start = 1; saddr = 6'd20; @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1; saddr = 6'd33; cfg_h2 = 0; cfg_er = 0; @(negedge clk); start = 0;
    @(negedge clk);
    check("R2", 32'(mem_addr), 32'(m_addr));
    check("R2", 32'(mem_addr != 6'd33), 1);
    repeat (3) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    repeat (3) @(negedge clk);
    check("R10", 32'(dout), 0);
    check("R10", 32'(wait_s), 1);
    check("R10", 32'(m_act), 0);

    // random bursts over all configurations
    for (int b = 0; b < 80; b++) begin
      burst(AW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1 + int'($urandom % 40), 20 + int'($urandom % 81));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule